// File: doc/BRIEF.md
# Four-Phase Bus Cycle Controller

This block sits between a processor core and a slow memory and turns each core request into a fixed sequence of bus phases. The first phase puts the address out. The second gives the memory time to latch it. The third is the data-access phase, where the memory finds the word. The fourth returns the word to the core with a one-clock done pulse. Writes follow the same sequence, with the write word on the bus from the second phase to the fourth.

Slow memory is handled by wait states, and these go only into the third phase. A count programmed on `ws_cfg_i` is taken when the request is accepted, and it adds that many whole clocks to phase three. Once the count has run out, the memory ready input is sampled at the close of each phase-three clock. Every clock in which that input is low adds one more clock. A zero-wait access therefore takes four clocks, and each added wait makes it one clock longer.

Top module: `bus_phase_ctrl`

## Requirements
- R1: While `rst_ni` is low, and in the cycle after it is released with no request, `bus_as_o`, `bus_rd_o`, `bus_wr_o`, `done_o` are 0, `bus_addr_o` and `bus_wdata_o` are 0, and `rdata_o` is 0.
- R2: A request (`req_i` = 1) is accepted only at a clock edge where the controller is idle. In the next clock (phase one), `bus_as_o` is 1, `bus_addr_o` shows the accepted address, and both `bus_rd_o` and `bus_wr_o` are 0.
- R3: From phase two to phase four, `bus_rd_o` (when `we_i` was 0 at acceptance) or `bus_wr_o` (when it was 1) is high, never both at once. `bus_addr_o` stays unchanged from phase one to phase four.
- R4: With a programmed count of 0 and ready high, `done_o` is high in the fourth clock after acceptance.
- R5: A programmed count of N, taken from `ws_cfg_i` at acceptance, places `done_o` in clock 4+N.
- R6: The ready input `mem_rdy_i` (1 = ready) is ignored during the programmed wait clocks. After them, each phase-three clock that ends with it low adds exactly one clock.
- R7: For a read, `rdata_o` takes `bus_rdata_i` as sampled at the edge that closes the last phase-three clock. It holds that value in phase four and afterwards until the next read captures. A write leaves `rdata_o` unchanged.
- R8: `bus_wdata_o` carries the accepted write word whenever `bus_wr_o` is high, and is 0 at all other times.
- R9: A request raised while an access is in progress is ignored. The address and timing of the running access are unchanged, and no new access follows unless `req_i` is high in an idle cycle.
- R10: `done_o` lasts exactly one clock. The clock after it is idle, with `bus_as_o`, `bus_rd_o` and `bus_wr_o` all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core access request, sampled when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Core address |
| wdata_i | input | DATA_W | Core write word |
| ws_cfg_i | input | WS_W | Programmed wait-state count |
| mem_rdy_i | input | 1 | Memory ready; low extends phase three |
| bus_rdata_i | input | DATA_W | Data from memory |
| done_o | output | 1 | One-clock completion pulse in phase four |
| rdata_o | output | DATA_W | Captured read word |
| bus_addr_o | output | ADDR_W | Address to memory, phases one to four |
| bus_as_o | output | 1 | Address valid strobe, phases one to four |
| bus_rd_o | output | 1 | Read strobe, phases two to four |
| bus_wr_o | output | 1 | Write strobe, phases two to four |
| bus_wdata_o | output | DATA_W | Write word to memory |

## Verification
The two sources of wait states can meet in one clock. The last programmed wait clock may be the same clock in which the memory pulls ready low. Only the ready value seen once the count has reached zero may lengthen the access. The bench provokes this by holding ready low for exactly the programmed wait clocks and nowhere else, and then expects an access of 4+N clocks. In the opposite case it holds ready low just after the count runs out and expects one extra clock per low cycle. The length is judged by counting clocks from acceptance to `done_o`.

// File: rtl/bus_phase_pkg.sv
package bus_phase_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_LATCH = 3'd2,
    PH_DATA  = 3'd3,
    PH_CAPT  = 3'd4
  } phase_e;
endpackage

// File: rtl/bus_wait_ctr.sv
module bus_wait_ctr #(
  parameter int WS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [WS_W-1:0] load_val_i,
  input  logic            dec_i,
  output logic            zero_o
);
  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/bus_phase_fsm.sv
module bus_phase_fsm
  import bus_phase_pkg::*;
#(
  parameter bit USE_RDY = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  logic   waits_zero_i,
  input  logic   mem_rdy_i,
  output phase_e phase_o,
  output logic   accept_o,
  output logic   wait_dec_o,
  output logic   data_end_o
);
  phase_e phase_q, phase_d;
  logic   rdy_eff;

  // variant: honour the memory ready line or run on the programmed count only
  generate
    if (USE_RDY) begin : g_rdy
      assign rdy_eff = mem_rdy_i;
    end else begin : g_no_rdy
      logic unused_rdy;
      assign unused_rdy = mem_rdy_i;
      assign rdy_eff    = 1'b1;
    end
  endgenerate

  assign accept_o   = (phase_q == PH_IDLE) && req_i;
  assign wait_dec_o = (phase_q == PH_DATA) && !waits_zero_i;
  // ready only counts once the programmed waits are spent
  assign data_end_o = (phase_q == PH_DATA) && waits_zero_i && rdy_eff;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (req_i) phase_d = PH_ADDR;
      PH_ADDR:  phase_d = PH_LATCH;
      PH_LATCH: phase_d = PH_DATA;
      PH_DATA:  if (data_end_o) phase_d = PH_CAPT;
      PH_CAPT:  phase_d = PH_IDLE;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/bus_phase_dp.sv
module bus_phase_dp #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              data_end_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [ADDR_W-1:0] addr_q_o,
  output logic              we_q_o,
  output logic [DATA_W-1:0] wdata_q_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o  <= '0;
      we_q_o    <= 1'b0;
      wdata_q_o <= '0;
    end else if (accept_i) begin
      addr_q_o  <= addr_i;
      we_q_o    <= we_i;
      wdata_q_o <= wdata_i;
    end
  end

  // hold register: loads at the edge closing the data phase, reads only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   rdata_o <= '0;
    else if (data_end_i && !we_q_o) rdata_o <= bus_rdata_i;
  end
endmodule

// File: rtl/bus_phase_ctrl.sv
module bus_phase_ctrl
  import bus_phase_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int WS_W    = 4,
  parameter bit USE_RDY = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [WS_W-1:0]   ws_cfg_i,
  input  logic              mem_rdy_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_as_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_wdata_o
);
  phase_e            phase;
  logic              accept, wait_dec, data_end, waits_zero;
  logic [ADDR_W-1:0] addr_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              active, strobe;

  bus_phase_fsm #(.USE_RDY(USE_RDY)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .waits_zero_i (waits_zero),
    .mem_rdy_i    (mem_rdy_i),
    .phase_o      (phase),
    .accept_o     (accept),
    .wait_dec_o   (wait_dec),
    .data_end_o   (data_end)
  );

  bus_wait_ctr #(.WS_W(WS_W)) u_wait (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (ws_cfg_i),
    .dec_i      (wait_dec),
    .zero_o     (waits_zero)
  );

  bus_phase_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .data_end_i  (data_end),
    .addr_i      (addr_i),
    .we_i        (we_i),
    .wdata_i     (wdata_i),
    .bus_rdata_i (bus_rdata_i),
    .addr_q_o    (addr_q),
    .we_q_o      (we_q),
    .wdata_q_o   (wdata_q),
    .rdata_o     (rdata_o)
  );

  assign active      = (phase != PH_IDLE);
  assign strobe      = (phase == PH_LATCH) || (phase == PH_DATA) || (phase == PH_CAPT);
  assign bus_as_o    = active;
  assign bus_addr_o  = active ? addr_q : '0;
  assign bus_rd_o    = strobe && !we_q;
  assign bus_wr_o    = strobe && we_q;
  assign bus_wdata_o = bus_wr_o ? wdata_q : '0;
  assign done_o      = (phase == PH_CAPT);
endmodule

// File: rtl/bus_phase_ctrl_chk.sv
module bus_phase_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_as_o,
  input logic              bus_rd_o,
  input logic              bus_wr_o,
  input logic [DATA_W-1:0] bus_wdata_o
);
  // R2
  phase_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_as_o) |-> (!bus_rd_o && !bus_wr_o));
  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_o || bus_wr_o) |-> (bus_as_o && !(bus_rd_o && bus_wr_o)));
  // R3
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_as_o && !$rose(bus_as_o)) |-> $stable(bus_addr_o));
  // R4
  done_in_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bus_as_o && (bus_rd_o || bus_wr_o)));
  // R7
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_o |=> $stable(rdata_o));
  // R8
  wdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr_o |-> (bus_wdata_o == '0));
  // R9
  no_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_as_o && !done_o) |=> bus_as_o);
  // R10
  done_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !bus_as_o && !bus_rd_o && !bus_wr_o));
endmodule

bind bus_phase_ctrl bus_phase_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .rdata_o     (rdata_o),
  .bus_addr_o  (bus_addr_o),
  .bus_as_o    (bus_as_o),
  .bus_rd_o    (bus_rd_o),
  .bus_wr_o    (bus_wr_o),
  .bus_wdata_o (bus_wdata_o)
);

// File: tb/bus_phase_ctrl_tb.sv
module bus_phase_ctrl_tb;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WW = 4;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [WW-1:0] ws;
    logic [3:0]    extra;
    logic [DW-1:0] rdat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h1234, 16'h0000, 4'd0,  4'd0, 16'hBEEF},
    '{1'b1, 16'h0040, 16'h5A5A, 4'd0,  4'd0, 16'h1111},
    '{1'b0, 16'h2002, 16'h0000, 4'd2,  4'd0, 16'h0F0F},
    '{1'b0, 16'h3003, 16'h0000, 4'd0,  4'd3, 16'hA5A5},
    '{1'b1, 16'h4004, 16'hC3C3, 4'd3,  4'd2, 16'h2222},
    '{1'b0, 16'hFFFE, 16'h0000, 4'd15, 4'd1, 16'hFFFF}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [WW-1:0] ws_cfg_i = '0;
  logic          mem_rdy_i = 1'b1;
  logic [DW-1:0] bus_rdata_i = '0;
  logic          done_o;
  logic [DW-1:0] rdata_o;
  logic [AW-1:0] bus_addr_o;
  logic          bus_as_o, bus_rd_o, bus_wr_o;
  logic [DW-1:0] bus_wdata_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] last_rd = '0;

  always #5 clk_i = ~clk_i;

  bus_phase_ctrl #(.ADDR_W(AW), .DATA_W(DW), .WS_W(WW)) u_dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .ws_cfg_i,
    .mem_rdy_i, .bus_rdata_i, .done_o, .rdata_o, .bus_addr_o,
    .bus_as_o, .bus_rd_o, .bus_wr_o, .bus_wdata_o
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one access; early_nr holds ready low only over the programmed waits, intrude raises req mid-access
  task automatic run_access(input vec_t v, input bit early_nr, input bit intrude);
    int cyc;
    int exp_len;
    exp_len = early_nr ? 4 + int'(v.ws) : 4 + int'(v.ws) + int'(v.extra);
    @(negedge clk_i);
    req_i = 1'b1; we_i = v.we; addr_i = v.addr; wdata_i = v.wdata;
    ws_cfg_i = v.ws; bus_rdata_i = v.rdat; mem_rdy_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0; ws_cfg_i = '0;
    cyc = 1;
    chk(bus_as_o && !bus_rd_o && !bus_wr_o, "R2 phase one strobes", {bus_as_o, bus_rd_o, bus_wr_o}, 3'b100);
    chk(bus_addr_o == v.addr, "R2 address", bus_addr_o, v.addr);
    while (cyc < 64) begin
      if (early_nr) mem_rdy_i = !(cyc >= 3 && cyc < 3 + int'(v.ws));
      else          mem_rdy_i = !(cyc >= 3 + int'(v.ws) && cyc < 3 + int'(v.ws) + int'(v.extra));
      if (intrude && cyc == 2) begin req_i = 1'b1; addr_i = ~v.addr; end
      if (intrude && cyc == 3) req_i = 1'b0;
      if (cyc == 2) begin
        chk(bus_rd_o == !v.we && bus_wr_o == v.we, "R3 phase two strobe", {bus_rd_o, bus_wr_o}, {!v.we, v.we});
        if (v.we) chk(bus_wdata_o == v.wdata, "R8 write word", bus_wdata_o, v.wdata);
      end
      if (intrude && cyc == 4) chk(bus_addr_o == v.addr, "R9 address kept", bus_addr_o, v.addr);
      if (done_o) break;
      @(negedge clk_i);
      cyc++;
    end
    chk(cyc == exp_len, "R4 R5 R6 access length", cyc, exp_len);
    bus_rdata_i = ~v.rdat;
    if (!v.we) last_rd = v.rdat;
    chk(rdata_o == last_rd, "R7 read word in phase four", rdata_o, last_rd);
    if (v.we) chk(bus_wr_o && bus_wdata_o == v.wdata, "R8 write word in phase four", bus_wdata_o, v.wdata);
    mem_rdy_i = 1'b1;
    @(negedge clk_i);
    chk(!done_o && !bus_as_o && !bus_rd_o && !bus_wr_o, "R10 idle after done",
        {done_o, bus_as_o, bus_rd_o, bus_wr_o}, 4'b0000);
    chk(bus_wdata_o == '0, "R8 write word cleared", bus_wdata_o, 0);
    chk(rdata_o == last_rd, "R7 read word held", rdata_o, last_rd);
    if (intrude) begin
      repeat (3) begin
        @(negedge clk_i);
        chk(!bus_as_o, "R9 no access from ignored request", bus_as_o, 0);
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL WDOG run hung actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1;
    chk(!bus_as_o && !bus_rd_o && !bus_wr_o && !done_o, "R1 reset strobes",
        {bus_as_o, bus_rd_o, bus_wr_o, done_o}, 0);
    chk(rdata_o == '0 && bus_addr_o == '0 && bus_wdata_o == '0, "R1 reset data", rdata_o, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!bus_as_o && !done_o, "R1 idle after release", {bus_as_o, done_o}, 0);

    for (int i = 0; i < NV; i++) run_access(VECS[i], 1'b0, 1'b0);

    // R6: ready low during the programmed waits only, count end and ready sample coincide
    run_access('{1'b0, 16'h5005, 16'h0000, 4'd4, 4'd0, 16'h6C6C}, 1'b1, 1'b0);
    run_access('{1'b0, 16'h5006, 16'h0000, 4'd1, 4'd2, 16'h7D7D}, 1'b1, 1'b0);
    // R7: write does not disturb the held read word
    run_access('{1'b1, 16'h6006, 16'h9999, 4'd1, 4'd0, 16'h0001}, 1'b0, 1'b0);
    // R9: request raised mid-access is ignored
    run_access('{1'b0, 16'h7007, 16'h0000, 4'd2, 4'd1, 16'h3C3C}, 1'b0, 1'b1);

    // R1: reset in the middle of an access
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 16'h8008; wdata_i = 16'h1357; ws_cfg_i = 4'd5;
    @(negedge clk_i);
    req_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk(!bus_as_o && !bus_wr_o && bus_wdata_o == '0 && rdata_o == '0, "R1 reset mid access",
        {bus_as_o, bus_wr_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    last_rd = '0;
    run_access('{1'b0, 16'h9009, 16'h0000, 4'd0, 4'd0, 16'h4242}, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule